// File: doc/BRIEF.md
# Frame Clock Ratio Monitor

This block watches the relation between the master clock and a slower frame clock. It counts master-clock cycles between successive rising edges of the frame clock. It compares each count with a nominal ratio of 128 or 256, chosen by a configuration pin. When a measured period strays too far from the nominal, or when the frame clock stops altogether, the block latches a frame-clock error.

The frame-clock error sits in a small status register beside a latched master-clock error, which is raised whenever the PLL reports loss of lock. The same register carries a live volume-busy bit and a live aggregate "all good" bit. The aggregate bit is high only when every channel-valid input is high and neither latched error is set. A simple one-cycle read port returns a fixed identification byte, the status byte, or the last measured period. Reading the status byte clears the latched errors.

Top module: `frame_ratio_monitor`

## Requirements
- R1: With `ratio_sel` low the nominal period is 128 master clocks; with it high the nominal is 256.
- R2: The frame clock passes through a two-flop synchronizer. The measured period is the number of master clocks between two successive rising frame edges. Address 2 returns period bits 7:0 and address 3 returns bit 8 in bit 0, with the upper bits zero.
- R3: A measured period whose distance from the nominal exceeds 10 cycles sets the frame error (status bit 0). A period within 10 cycles of the nominal does not set it.
- R4: The first rising frame edge after reset only starts measurement. The partial period before it is never evaluated.
- R5: The period counter saturates at 511. Once measurement has started, a frame clock with no rising edge for that long sets the frame error, and the next edge records 511.
- R6: Any cycle with `pll_locked` low sets the master-clock error (status bit 1).
- R7: Both error bits stay set until a read of the status address (1), which clears them. A set condition in the same cycle as the clearing read leaves the bit set.
- R8: Status bit 2 reports `vol_busy` as sampled in the read cycle.
- R9: Status bit 3 is high only when all `ch_valid` bits are high and both error bits are clear. Status bits 7:4 read zero.
- R10: Address 0 returns the fixed identification byte 0xA5.
- R11: Read data appears the cycle after `rd_en` and holds until the next read.
- R12: After reset `rd_data` is zero and both error bits are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Frame clock, asynchronous to `clk` |
| ratio_sel | input | 1 | Nominal ratio select: 0 = 128, 1 = 256 |
| ch_valid | input | N_CH | Per-channel valid flags |
| vol_busy | input | 1 | Volume update in progress |
| pll_locked | input | 1 | PLL lock indication, high when in sync |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 9-bit counter, a tolerance of 10, six channels and a two-stage synchronizer. With these values saturation is reached within a few hundred cycles. This keeps the stopped-clock case cheap. The bench sweeps every period from 13 below to 13 above each nominal for both ratio settings, so both sides of each tolerance edge are hit exactly. Six channels allow each valid input to be dropped on its own.

// File: rtl/frm_mon_pkg.sv
package frm_mon_pkg;

   localparam int DATA_W = 8;

   typedef enum logic [1:0] {
      RA_IDENT  = 2'd0,
      RA_STATUS = 2'd1,
      RA_CNT_LO = 2'd2,
      RA_CNT_HI = 2'd3
   } reg_addr_e;

   typedef struct packed {
      logic [3:0] spare;
      logic       all_good;
      logic       vol_busy;
      logic       clk_err;
      logic       frame_err;
   } status_t;

endpackage

// File: rtl/frm_edge_sync.sv
module frm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("frm_edge_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else if (s == 0) chain[s] <= async_in;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;

   AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise); // R2

endmodule

// File: rtl/frm_period_counter.sv
module frm_period_counter #(
   parameter int CNT_W  = 9,
   parameter int TOL    = 10,
   parameter int NOM_LO = 128,
   parameter int NOM_HI = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             ratio_sel,
   output logic [CNT_W-1:0] meas,
   output logic             err_pulse
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] NOM_A   = CNT_W'(NOM_LO);
   localparam logic [CNT_W-1:0] NOM_B   = CNT_W'(NOM_HI);
   localparam logic [CNT_W-1:0] TOL_V   = CNT_W'(TOL);

   if ((NOM_HI + TOL) >= (1 << CNT_W)) begin : g_bad_width
      $error("frm_period_counter: CNT_W too narrow for NOM_HI plus TOL");
   end
   if (NOM_LO <= TOL) begin : g_bad_nom
      $error("frm_period_counter: NOM_LO must exceed TOL");
   end

   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic [CNT_W-1:0] nominal;
   logic [CNT_W-1:0] dev;
   logic             out_of_tol;

   assign nominal = ratio_sel ? NOM_B : NOM_A;
   assign dev     = (cnt > nominal) ? (cnt - nominal) : (nominal - cnt);

   if (TOL == 0) begin : g_exact
      assign out_of_tol = (cnt != nominal);
   end else begin : g_window
      assign out_of_tol = (dev > TOL_V);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         meas  <= '0;
      end else if (rise) begin
         if (armed) meas <= cnt;
         armed <= 1'b1;
         cnt   <= CNT_W'(1);
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_pulse <= 1'b0;
      else err_pulse <= armed & ((rise & out_of_tol) | (cnt == CNT_MAX));
   end

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) && !rise |=> (cnt == CNT_MAX)); // R5
   AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !err_pulse); // R4

endmodule

// File: rtl/frm_status_regs.sv
module frm_status_regs
   import frm_mon_pkg::*;
#(
   parameter int          CNT_W  = 9,
   parameter int          N_CH   = 6,
   parameter logic [7:0]  DEV_ID = 8'hA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_err_set,
   input  logic              pll_locked,
   input  logic              vol_busy,
   input  logic [N_CH-1:0]   ch_valid,
   input  logic [CNT_W-1:0]  meas,
   input  logic              rd_en,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HI_W = CNT_W - DATA_W;

   if (CNT_W <= DATA_W || CNT_W > 2*DATA_W) begin : g_bad_cnt
      $error("frm_status_regs: CNT_W must lie in 9..16");
   end

   logic        fe_q;
   logic        ce_q;
   logic        clr;
   logic        valid_all;
   status_t     stat;
   logic [DATA_W-1:0] rd_mux;

   assign clr = rd_en & (reg_addr_e'(rd_addr) == RA_STATUS);

   if (N_CH == 1) begin : g_one_ch
      assign valid_all = ch_valid[0];
   end else begin : g_many_ch
      assign valid_all = &ch_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fe_q <= 1'b0;
         ce_q <= 1'b0;
      end else begin
         fe_q <= frame_err_set | (fe_q & ~clr);
         ce_q <= ~pll_locked   | (ce_q & ~clr);
      end
   end

   always_comb begin
      stat           = '0;
      stat.frame_err = fe_q;
      stat.clk_err   = ce_q;
      stat.vol_busy  = vol_busy;
      stat.all_good  = valid_all & ~fe_q & ~ce_q;
   end

   always_comb begin
      unique case (reg_addr_e'(rd_addr))
         RA_IDENT:  rd_mux = DEV_ID;
         RA_STATUS: rd_mux = stat;
         RA_CNT_LO: rd_mux = meas[DATA_W-1:0];
         default:   rd_mux = DATA_W'(meas[CNT_W-1:DATA_W]);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_set |=> fe_q); // R7
   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      clr && pll_locked |=> !ce_q); // R7
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ce_q && !clr |=> ce_q); // R7
   AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_locked |=> ce_q); // R6

   if (HI_W < 1) begin : g_never
      $error("frm_status_regs: no upper count bits");
   end

endmodule

// File: rtl/frame_ratio_monitor.sv
module frame_ratio_monitor
   import frm_mon_pkg::*;
#(
   parameter int         CNT_W       = 9,
   parameter int         TOL         = 10,
   parameter int         NOM_LO      = 128,
   parameter int         NOM_HI      = 256,
   parameter int         N_CH        = 6,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] DEV_ID      = 8'hA5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_clk,
   input  logic            ratio_sel,
   input  logic [N_CH-1:0] ch_valid,
   input  logic            vol_busy,
   input  logic            pll_locked,
   input  logic            rd_en,
   input  logic [1:0]      rd_addr,
   output logic [7:0]      rd_data
);

   if (N_CH < 1) begin : g_bad_ch
      $error("frame_ratio_monitor: N_CH must be at least 1");
   end

   logic             frame_rise;
   logic [CNT_W-1:0] meas;
   logic             err_pulse;

   frm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (frame_clk),
      .rise     (frame_rise)
   );

   frm_period_counter #(
      .CNT_W  (CNT_W),
      .TOL    (TOL),
      .NOM_LO (NOM_LO),
      .NOM_HI (NOM_HI)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (frame_rise),
      .ratio_sel (ratio_sel),
      .meas      (meas),
      .err_pulse (err_pulse)
   );

   frm_status_regs #(
      .CNT_W  (CNT_W),
      .N_CH   (N_CH),
      .DEV_ID (DEV_ID)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_err_set (err_pulse),
      .pll_locked    (pll_locked),
      .vol_busy      (vol_busy),
      .ch_valid      (ch_valid),
      .meas          (meas),
      .rd_en         (rd_en),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data)
   );

   AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == 2'd0 |=> rd_data == DEV_ID); // R10
   AST_NOERR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == 2'd1 && !(&ch_valid) |=> !rd_data[3]); // R9
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data)); // R11
   AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && rd_addr == 2'd1 |=> rd_data[2] == $past(vol_busy)); // R8

endmodule

// File: tb/frame_ratio_monitor_test.sv
`timescale 1ns/1ps
module frame_ratio_monitor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic       ratio_sel = 1'b0;
   logic [5:0] ch_valid = 6'h3F;
   logic       vol_busy = 1'b0;
   logic       pll_locked = 1'b1;
   logic       rd_en = 1'b0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   frame_ratio_monitor uut (
      .clk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .ratio_sel(ratio_sel),
      .ch_valid(ch_valid), .vol_busy(vol_busy), .pll_locked(pll_locked),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      frame_clk = 1'b0;
      rd_en = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frames(int per, int n);
      for (int i = 0; i < n; i++) begin
         frame_clk = 1'b1;
         repeat (per / 2) @(negedge clk);
         frame_clk = 1'b0;
         repeat (per - per / 2) @(negedge clk);
      end
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   initial begin
      #(4ns * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int nom, exp_err;

      do_reset();
      @(negedge clk);
      check("R12 rd_data after reset", rd_data, 0);
      rd(2'd1, v);
      check("R12 status after reset", v, 8'h08);
      rd(2'd0, v);
      check("R10 ident", v, 8'hA5);

      // R1 R2 R3 sweep around both nominals
      for (int r = 0; r < 2; r++) begin
         nom = (r == 0) ? 128 : 256;
         for (int p = nom - 13; p <= nom + 13; p++) begin
            ratio_sel = r[0];
            do_reset();
            idle(20);
            frames(p, 3);
            rd(2'd2, v);
            check("R2 count low", v, p & 8'hFF);
            rd(2'd3, v);
            check("R2 count high", v, p >> 8);
            exp_err = ((p > nom ? p - nom : nom - p) > 10) ? 1 : 0;
            rd(2'd1, v);
            check(r == 0 ? "R3 R1 status ratio 128" : "R3 R1 status ratio 256",
                  v, exp_err ? 8'h01 : 8'h08);
         end
      end

      // R4 long partial period before first edge is ignored
      ratio_sel = 1'b0;
      do_reset();
      idle(300);
      frames(128, 3);
      rd(2'd1, v);
      check("R4 partial period ignored", v, 8'h08);

      // R5 stopped frame clock saturates
      do_reset();
      idle(20);
      frames(128, 2);
      idle(600);
      rd(2'd1, v);
      check("R5 stopped clock error", v, 8'h01);
      frames(128, 1);
      rd(2'd2, v);
      check("R5 saturated count low", v, 8'hFF);
      rd(2'd3, v);
      check("R5 saturated count high", v, 8'h01);

      // R7 read clears frame error
      do_reset();
      idle(20);
      frames(100, 3);
      rd(2'd1, v);
      check("R7 error latched", v, 8'h01);
      rd(2'd1, v);
      check("R7 cleared by read", v, 8'h08);

      // R6 R7 lock loss
      do_reset();
      idle(5);
      pll_locked = 1'b0;
      idle(3);
      pll_locked = 1'b1;
      idle(5);
      rd(2'd1, v);
      check("R6 clk error latched", v, 8'h02);
      rd(2'd1, v);
      check("R7 clk error cleared", v, 8'h08);
      pll_locked = 1'b0;
      rd(2'd1, v);
      rd(2'd1, v);
      check("R7 set wins over clear", v, 8'h02);
      pll_locked = 1'b1;
      idle(2);
      rd(2'd1, v);
      rd(2'd1, v);
      check("R7 clear after lock restored", v, 8'h08);

      // R8 busy live
      vol_busy = 1'b1;
      rd(2'd1, v);
      check("R8 busy high", v, 8'h0C);
      vol_busy = 1'b0;
      rd(2'd1, v);
      check("R8 busy low", v, 8'h08);

      // R9 each valid dropped alone
      for (int c = 0; c < 6; c++) begin
         ch_valid = 6'h3F & ~(6'h01 << c);
         rd(2'd1, v);
         check("R9 one valid low", v, 8'h00);
      end
      ch_valid = 6'h3F;
      rd(2'd1, v);
      check("R9 all valid", v, 8'h08);

      // R11 data held between reads
      rd(2'd0, v);
      vol_busy = 1'b1;
      idle(5);
      check("R11 hold after read", rd_data, 8'hA5);
      vol_busy = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule